// File: doc/BRIEF.md
# Two-Phase Refresh Sequencer for a Multiplying Delay Loop

This block sequences a multiplying delay loop that works in pairs of reference periods. In the first period, the refresh period, a reference edge is injected into the loop and the loop's output edges are counted. In the second period, the compare period, the count is held steady so that a downstream comparator and successive-approximation register can act on it. The block drives four things: the select that lets the injected edge into the delay line, the half-rate update clock for the approximation register, the counting-window strobe, and the saturating edge count with its valid pulse.

The three loop clocks are the reference, the internal clock (the reference after the input delay) and the loop output. All three enter as levels sampled by a fast fabric clock. They pass through identical synchronizer chains, so their relative order is kept. Every output is registered, and each one follows the input change that causes it by `SYNC_STAGES + 1` fabric cycles. The update clock lags by a further `SAR_DLY` cycles.

Top module: `mdll_refresh_ctrl`

## Requirements
- R1: While reset is low, select, window, count and valid are all 0 and the update clock is 1.
- R2: The first rising edge of the reference after reset starts a refresh period, and so does every second edge after it. Select goes to 1 on each of these edges.
- R3: Select falls on the first rising edge of the internal clock seen while select is 1. If no such edge comes, select falls on the reference edge that starts the compare period. A reference edge takes priority over an internal edge in the same cycle.
- R4: The update clock is 0 during refresh periods and 1 during compare periods, and it lags the period boundary by a further SAR_DLY cycles. Its period is therefore two reference periods.
- R5: The window strobe is the internal clock divided by two. It is 0 after reset and toggles on every rising edge of the internal clock.
- R6: The count is cleared to 0 in the same cycle that the window opens. An output edge that arrives in that cycle is not counted.
- R7: While the window is open, each rising edge of the output adds one to the count. This includes an edge that arrives in the cycle the window closes.
- R8: While the window is closed, the count holds its value.
- R9: The count stops at 2^CNT_W-1, which is 15 for the default width of 4. It never wraps.
- R10: The valid output pulses for exactly one cycle, in the same cycle that the window falls.
- R11: Select and the window strobe are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Reference clock level |
| int_i | input | 1 | Internal (delayed reference) clock level |
| out_i | input | 1 | Loop output clock level |
| sel_o | output | 1 | Injection select; 1 lets the reference edge into the delay line |
| sar_clk_o | output | 1 | Half-rate update clock for the approximation register |
| cnt_win_o | output | 1 | Counting window; falling edge stops the counter |
| count_o | output | CNT_W | Output edges counted in the last window |
| count_vld_o | output | 1 | One-cycle pulse when count_o becomes final |

## Verification
Several rules are checked on every cycle by the checker, using only the block's ports. These are that select and window never overlap, that the count is cleared when the window opens, that the count holds while the window is closed and never goes down, and that the valid pulse coincides exactly with the window closing. Other behaviour depends on how the three loop clocks are interleaved. This covers the select timing against the internal edge, the update-clock phase and lag, the exact edge count and saturation, the window parity after an internal edge goes missing, and the rule that an edge coinciding with the window opening is not counted. Only the bench's reference model, replayed at the fixed output lag, can confirm these.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
   localparam int unsigned NUM_CLK_IN = 3;
   localparam int unsigned IDX_REF    = 0;
   localparam int unsigned IDX_INT    = 1;
   localparam int unsigned IDX_OUT    = 2;

   typedef enum logic {
      PH_COMPARE = 1'b0,
      PH_REFRESH = 1'b1
   } phase_e;

   typedef struct packed {
      logic win;
      logic open;
      logic close;
   } win_evt_t;
endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q[0] <= lvl_i;
         for (int k = 1; k < int'(STAGES); k++) begin
            chain_q[k] <= chain_q[k-1];
         end
         last_q <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rfc_phase_seq.sv
module rfc_phase_seq
   import rfc_pkg::*;
#(
   parameter int unsigned SAR_DLY = 2
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     ref_rise_i,
   input  logic     int_rise_i,
   output logic     sel_o,
   output logic     sar_clk_o,
   output win_evt_t win_o
);
   phase_e phase_q;
   logic   sel_q;
   logic   win_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= PH_COMPARE;
         sel_q   <= 1'b0;
         win_q   <= 1'b0;
      end else begin
         if (ref_rise_i) begin
            phase_q <= (phase_q == PH_COMPARE) ? PH_REFRESH : PH_COMPARE;
            sel_q   <= (phase_q == PH_COMPARE);
         end else if (int_rise_i) begin
            sel_q <= 1'b0;
         end
         if (int_rise_i) begin
            win_q <= ~win_q;
         end
      end
   end

   generate
      if (SAR_DLY == 0) begin : g_sar_direct
         assign sar_clk_o = (phase_q == PH_COMPARE);
      end else begin : g_sar_delayed
         logic [SAR_DLY-1:0] pipe_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               pipe_q <= '1;
            end else begin
               pipe_q[0] <= (phase_q == PH_COMPARE);
               for (int k = 1; k < int'(SAR_DLY); k++) begin
                  pipe_q[k] <= pipe_q[k-1];
               end
            end
         end
         assign sar_clk_o = pipe_q[SAR_DLY-1];
      end
   endgenerate

   assign sel_o       = sel_q;
   assign win_o.win   = win_q;
   assign win_o.open  = int_rise_i & ~win_q;
   assign win_o.close = int_rise_i & win_q;
endmodule

// File: rtl/rfc_edge_counter.sv
module rfc_edge_counter
   import rfc_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  win_evt_t         win_i,
   input  logic             out_rise_i,
   output logic [CNT_W-1:0] count_o,
   output logic             vld_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             vld_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         vld_q <= 1'b0;
      end else begin
         if (win_i.open) begin
            cnt_q <= '0;
         end else if (win_i.win && out_rise_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
         vld_q <= win_i.close;
      end
   end

   assign count_o = cnt_q;
   assign vld_o   = vld_q;
endmodule

// File: rtl/mdll_refresh_ctrl.sv
module mdll_refresh_ctrl
   import rfc_pkg::*;
#(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SAR_DLY     = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_i,
   input  logic             int_i,
   input  logic             out_i,
   output logic             sel_o,
   output logic             sar_clk_o,
   output logic             cnt_win_o,
   output logic [CNT_W-1:0] count_o,
   output logic             count_vld_o
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("CNT_W must lie in 2..16");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
      if (SAR_DLY > 8) begin : g_bad_sar_dly
         $error("SAR_DLY must not exceed 8");
      end
   endgenerate

   logic [NUM_CLK_IN-1:0] lvl;
   logic [NUM_CLK_IN-1:0] rise;
   win_evt_t              win;

   assign lvl[IDX_REF] = ref_i;
   assign lvl[IDX_INT] = int_i;
   assign lvl[IDX_OUT] = out_i;

   generate
      for (genvar g = 0; g < int'(NUM_CLK_IN); g++) begin : g_sync
         rfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lvl_i  (lvl[g]),
            .rise_o (rise[g])
         );
      end
   endgenerate

   rfc_phase_seq #(.SAR_DLY(SAR_DLY)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_rise_i (rise[IDX_REF]),
      .int_rise_i (rise[IDX_INT]),
      .sel_o      (sel_o),
      .sar_clk_o  (sar_clk_o),
      .win_o      (win)
   );

   rfc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .win_i      (win),
      .out_rise_i (rise[IDX_OUT]),
      .count_o    (count_o),
      .vld_o      (count_vld_o)
   );

   assign cnt_win_o = win.win;
endmodule

// File: rtl/mdll_refresh_ctrl_chk.sv
module mdll_refresh_ctrl_chk #(
   parameter int unsigned CNT_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sel_o,
   input logic             cnt_win_o,
   input logic [CNT_W-1:0] count_o,
   input logic             count_vld_o
);
   assert_sel_win_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sel_o && cnt_win_o));

   assert_clear_on_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cnt_win_o) |-> (count_o == '0));

   assert_hold_closed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_win_o |=> (cnt_win_o || $stable(count_o)));

   assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_win_o && $past(cnt_win_o)) |-> (count_o >= $past(count_o)));

   assert_vld_on_close_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cnt_win_o) |-> count_vld_o);

   assert_vld_only_close_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_vld_o |-> ($past(cnt_win_o) && !cnt_win_o));
endmodule

bind mdll_refresh_ctrl mdll_refresh_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sel_o       (sel_o),
   .cnt_win_o   (cnt_win_o),
   .count_o     (count_o),
   .count_vld_o (count_vld_o)
);

// File: tb/mdll_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module mdll_refresh_ctrl_tb;
   localparam int SYNC = 2;
   localparam int SDLY = 2;
   localparam int CW   = 4;
   localparam int LAG  = SYNC + 1;
   localparam int HD   = 16;
   localparam logic [CW-1:0] MAXC = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_l = 1'b0, int_l = 1'b0, out_l = 1'b0;
   logic sel, sar, win, vld;
   logic [CW-1:0] cnt;

   always #2.5 clk = ~clk;

   mdll_refresh_ctrl #(.CNT_W(CW), .SYNC_STAGES(SYNC), .SAR_DLY(SDLY)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_l), .int_i(int_l), .out_i(out_l),
      .sel_o(sel), .sar_clk_o(sar), .cnt_win_o(win), .count_o(cnt), .count_vld_o(vld)
   );

   int tests = 0, fails = 0;
   bit done = 0;
   int cyc = HD;
   int oc = 0;

   logic e_sel[HD], e_sar[HD], e_win[HD], e_vld[HD], e_open[HD];
   logic [CW-1:0] e_cnt[HD];

   logic m_ph = 0, m_sel = 0, m_win = 0, m_vld = 0, m_open = 0;
   logic [CW-1:0] m_cnt = '0;
   logic p_ref = 0, p_int = 0, p_out = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic iv, input logic o);
      int ix, sx;
      string ctag;
      @(negedge clk);
      ix = (cyc - LAG) % HD;
      sx = (cyc - LAG - SDLY) % HD;
      chk(sel == e_sel[ix], e_sel[ix] ? "R2 select" : "R3 select", int'(sel), int'(e_sel[ix]));
      chk(sar == e_sar[sx], "R4 update clock", int'(sar), int'(e_sar[sx]));
      chk(win == e_win[ix], "R5 window", int'(win), int'(e_win[ix]));
      if (e_open[ix])          ctag = "R6 count clear";
      else if (e_cnt[ix] == MAXC) ctag = "R9 count saturate";
      else if (e_win[ix])      ctag = "R7 count edges";
      else                     ctag = "R8 count hold";
      chk(cnt == e_cnt[ix], ctag, int'(cnt), int'(e_cnt[ix]));
      chk(vld == e_vld[ix], "R10 valid pulse", int'(vld), int'(e_vld[ix]));
      chk(!(sel && win), "R11 select/window overlap", int'(sel && win), 0);
      ref_l = r; int_l = iv; out_l = o;
      // reference model
      m_vld = 0; m_open = 0;
      if (r && !p_ref) begin
         m_sel = !m_ph;
         m_ph  = !m_ph;
      end else if (iv && !p_int) begin
         m_sel = 0;
      end
      if (iv && !p_int) begin
         if (m_win) begin
            if (o && !p_out && m_cnt != MAXC) m_cnt = m_cnt + 1'b1;
            m_win = 0; m_vld = 1;
         end else begin
            m_win = 1; m_cnt = '0; m_open = 1;
         end
      end else if (m_win && o && !p_out && m_cnt != MAXC) begin
         m_cnt = m_cnt + 1'b1;
      end
      p_ref = r; p_int = iv; p_out = o;
      e_sel[cyc % HD] = m_sel; e_sar[cyc % HD] = !m_ph; e_win[cyc % HD] = m_win;
      e_vld[cyc % HD] = m_vld; e_cnt[cyc % HD] = m_cnt; e_open[cyc % HD] = m_open;
      cyc++;
   endtask

   task automatic seg(input int per, input int dly, input int oh, input int nper, input bit noint);
      for (int p = 0; p < nper; p++) begin
         for (int t = 0; t < per; t++) begin
            logic r, iv, o, irise;
            int nxt;
            r  = (t < per / 2);
            iv = noint ? 1'b0 : (((t - dly + per) % per) < per / 2);
            irise = iv && !p_int;
            nxt = oc + 1;
            // keep output edges off the cycles where the window toggles
            if (irise && ((nxt % (2 * oh)) == oh)) nxt = oc;
            oc = nxt;
            o = ((oc % (2 * oh)) >= oh);
            step(r, iv, o);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL R5 watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < HD; k++) begin
         e_sel[k] = 0; e_sar[k] = 1; e_win[k] = 0; e_vld[k] = 0; e_cnt[k] = '0; e_open[k] = 0;
      end
      repeat (4) @(negedge clk);
      chk(sel == 0 && win == 0 && vld == 0 && cnt == 0, "R1 reset outputs low",
          int'({sel, win, vld}) + int'(cnt), 0);
      chk(sar == 1, "R1 reset update clock high", int'(sar), 1);
      rst_n = 1'b1;
      // directed: fast output, saturation R9
      seg(32, 3, 1, 4, 0);
      // directed: slow output, few edges R7
      seg(40, 5, 8, 4, 0);
      // directed: almost no output edges R6/R8
      seg(20, 2, 30, 4, 0);
      // directed: internal edge missing for a full pair, select drops at compare R3
      seg(24, 4, 3, 2, 1);
      seg(24, 4, 3, 4, 0);
      // constrained random
      for (int s = 0; s < 14; s++) begin
         int per, dly, oh, np;
         per = 16 + 2 * int'($urandom % 17);
         dly = 1 + int'($urandom % (per / 2 - 2));
         oh  = 1 + int'($urandom % 8);
         np  = 2 * (2 + int'($urandom % 3));
         seg(per, dly, oh, np, 0);
      end
      // drain pipeline with quiet inputs
      for (int k = 0; k < LAG + SDLY + 2; k++) step(0, 0, out_l);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule